// File: doc/BRIEF.md
# Bus Master Request-Grant Controller

This block is the master-side logic that wins the address bus for a processor on a split-transaction bus. Internal logic hands it transaction requests. It keeps up to a parameterised number of them (two by default), including the one currently on the bus. It drives an active-low bus request and watches the external arbiter's active-low grant. When the grant qualifies, it fires a one-cycle active-low transfer-start strobe. An active-low address-tenure monitor output shows when this master owns the address bus.

The grant is sampled at every rising edge. It qualifies when all of the following hold at that edge:
- grant is asserted;
- address retry is negated;
- no address tenure of this master is in progress;
- at least one request is waiting.

Transfer start then appears in the next cycle. The master can therefore start in a cycle where the arbiter has already withdrawn the grant. Address acknowledge plays no part in the qualification. It only closes the tenure that is in progress.

An address retry received while a tenure is open puts the transaction back in the queue, and bus request is asserted again.

Top module: `busreq_ctl`

## Requirements
- R1: While rst is high, and in the first cycle after it falls, br_n, ts_n and amon_n are high and req_ready is high. Reset empties the queue.
- R2: br_n is low in every cycle in which at least one accepted request is waiting and not yet started. A request accepted at an edge shows on br_n in the following cycle.
- R3: ts_n goes low for exactly one cycle. That cycle directly follows an edge at which bg_n was low, artry_n was high, no tenure was open and a request was waiting.
- R4: ts_n is low only when bg_n was low at the preceding edge. A cycle in which bg_n is high may still carry the transfer start.
- R5: In the transfer-start cycle, br_n is high if no other request is waiting. It stays low if another request is waiting.
- R6: amon_n is low from the transfer-start cycle through the cycle in which aack_n is sampled low. It is high in the cycle after that. Acknowledge in the start cycle itself closes the tenure.
- R7: While a tenure is open, no new transfer start is issued, even with bg_n low. aack_n does not enter the grant qualification.
- R8: If artry_n is sampled low while a tenure is open, the transaction returns to the queue. In the next cycle amon_n is high and br_n is low. Retry wins over a simultaneous acknowledge.
- R9: artry_n sampled low at an edge prevents a transfer start from that edge, whatever bg_n is.
- R10: req_ready is high only while waiting plus in-flight transactions number fewer than DEPTH (2). A request offered while req_ready is low is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Internal logic offers one transaction |
| req_ready | output | 1 | Queue can take a transaction this cycle |
| bg_n | input | 1 | Bus grant from the arbiter, active low |
| artry_n | input | 1 | Address retry, active low |
| aack_n | input | 1 | Address acknowledge, active low |
| br_n | output | 1 | Bus request, active low |
| ts_n | output | 1 | Transfer start strobe, active low |
| amon_n | output | 1 | Address tenure monitor, active low |

## Verification
The bench goes after the following corner cases.

- **Grant withdrawn in the start cycle.** A controller that gated the strobe with the live grant would drop the transaction.
- **Grant held asserted throughout an open tenure.** A design that left its latched tenure flag out of the qualification would emit a second strobe.
- **Retry together with acknowledge.** If acknowledge won, the transaction would be lost and bus request would stay high.
- **Acknowledge in the start cycle.** This exposes a monitor that stretches past the acknowledge.
- **Queue full while requests keep arriving.** A counter that does not refuse them would wrap or start extra transactions.
- **Reset with work pending.** This shows whether reset truly empties the queue.

// File: rtl/busreq_pkg.sv
package busreq_pkg;

    typedef enum logic [1:0] {
        TEN_IDLE  = 2'd0,
        TEN_START = 2'd1,
        TEN_WAIT  = 2'd2
    } tenure_e;

    // active-high view of the sampled bus inputs
    typedef struct packed {
        logic grant;
        logic retry;
        logic ack;
    } bus_in_t;

    // active-high view of the driven bus outputs
    typedef struct packed {
        logic request;
        logic start;
        logic monitor;
    } bus_out_t;

    function automatic logic pin_to_level(input logic pin_n);
        return ~pin_n;
    endfunction

    function automatic logic level_to_pin(input logic level);
        return ~level;
    endfunction

endpackage

// File: rtl/busreq_pins.sv
module busreq_pins
    import busreq_pkg::*;
(
    input  logic     bg_n,
    input  logic     artry_n,
    input  logic     aack_n,
    input  bus_out_t drv,
    output bus_in_t  smp,
    output logic     br_n,
    output logic     ts_n,
    output logic     amon_n
);

    always_comb begin
        smp.grant = pin_to_level(bg_n);
        smp.retry = pin_to_level(artry_n);
        smp.ack   = pin_to_level(aack_n);
    end

    assign br_n   = level_to_pin(drv.request);
    assign ts_n   = level_to_pin(drv.start);
    assign amon_n = level_to_pin(drv.monitor);

endmodule

// File: rtl/busreq_queue.sv
module busreq_queue #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic launch,
    input  logic requeue,
    input  logic inflight,
    output logic have_work,
    output logic ready
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int SW = CW + 1;
    localparam logic [SW-1:0] LIMIT = SW'(DEPTH);

    logic [CW-1:0] waiting;
    logic [SW-1:0] held;
    logic [SW-1:0] next_wait;
    logic          take;

    assign held      = SW'(waiting) + SW'(inflight);
    assign ready     = held < LIMIT;
    assign take      = push & ready;
    assign have_work = waiting != '0;

    always_comb begin
        next_wait = SW'(waiting) + SW'(take) + SW'(requeue) - SW'(launch);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            waiting <= '0;
        end else begin
            waiting <= next_wait[CW-1:0];
        end
    end

endmodule

// File: rtl/busreq_tenure.sv
module busreq_tenure
    import busreq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_in_t smp,
    input  logic    have_work,
    output logic    launch,
    output logic    requeue,
    output logic    open_tenure,
    output logic    start
);

    tenure_e state, state_nx;

    assign open_tenure = state != TEN_IDLE;
    assign start       = state == TEN_START;

    // qualified grant: grant, no retry, no tenure open, work waiting
    assign launch  = smp.grant & ~smp.retry & ~open_tenure & have_work;
    assign requeue = open_tenure & smp.retry;

    always_comb begin
        state_nx = state;
        unique case (state)
            TEN_IDLE:  if (launch) state_nx = TEN_START;
            TEN_START: state_nx = (smp.retry | smp.ack) ? TEN_IDLE : TEN_WAIT;
            TEN_WAIT:  if (smp.retry | smp.ack) state_nx = TEN_IDLE;
            default:   state_nx = TEN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TEN_IDLE;
        end else begin
            state <= state_nx;
        end
    end

endmodule

// File: rtl/busreq_ctl.sv
module busreq_ctl
    import busreq_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    output logic req_ready,
    input  logic bg_n,
    input  logic artry_n,
    input  logic aack_n,
    output logic br_n,
    output logic ts_n,
    output logic amon_n
);

    bus_in_t  smp;
    bus_out_t drv;
    logic     have_work;
    logic     launch;
    logic     requeue;
    logic     open_tenure;
    logic     start;

    busreq_pins u_pins (
        .bg_n    (bg_n),
        .artry_n (artry_n),
        .aack_n  (aack_n),
        .drv     (drv),
        .smp     (smp),
        .br_n    (br_n),
        .ts_n    (ts_n),
        .amon_n  (amon_n)
    );

    busreq_queue #(.DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .push      (req_valid),
        .launch    (launch),
        .requeue   (requeue),
        .inflight  (open_tenure),
        .have_work (have_work),
        .ready     (req_ready)
    );

    busreq_tenure u_tenure (
        .clk         (clk),
        .rst         (rst),
        .smp         (smp),
        .have_work   (have_work),
        .launch      (launch),
        .requeue     (requeue),
        .open_tenure (open_tenure),
        .start       (start)
    );

    always_comb begin
        drv.request = have_work;
        drv.start   = start;
        drv.monitor = open_tenure;
    end

endmodule

// File: rtl/busreq_ctl_chk.sv
module busreq_ctl_chk (
    input logic clk,
    input logic rst,
    input logic bg_n,
    input logic artry_n,
    input logic aack_n,
    input logic br_n,
    input logic ts_n,
    input logic amon_n
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (br_n && ts_n && amon_n));

    // R3
    ts_single_chk: assert property (@(posedge clk) disable iff (rst)
        !ts_n |=> ts_n);

    // R4
    ts_needs_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ts_n) |-> $past(!bg_n));

    // R6
    amon_covers_ts_chk: assert property (@(posedge clk) disable iff (rst)
        !ts_n |-> !amon_n);

    // R6
    amon_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (!amon_n && !aack_n) |=> amon_n);

    // R7
    no_ts_in_tenure_chk: assert property (@(posedge clk) disable iff (rst)
        !amon_n |=> ts_n);

    // R8
    retry_rerequest_chk: assert property (@(posedge clk) disable iff (rst)
        (!amon_n && !artry_n) |=> (!br_n && amon_n));

    // R9
    retry_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        !artry_n |=> ts_n);

endmodule

bind busreq_ctl busreq_ctl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .bg_n    (bg_n),
    .artry_n (artry_n),
    .aack_n  (aack_n),
    .br_n    (br_n),
    .ts_n    (ts_n),
    .amon_n  (amon_n)
);

// File: tb/busreq_ctl_tb.sv
`timescale 1ns/1ps
module busreq_ctl_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic bg = 1'b0, artry = 1'b0, aack = 1'b0;
    logic req_ready, br_n, ts_n, amon_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    busreq_ctl #(.DEPTH(2)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .bg_n      (~bg),
        .artry_n   (~artry),
        .aack_n    (~aack),
        .br_n      (br_n),
        .ts_n      (ts_n),
        .amon_n    (amon_n)
    );

    // {req, bg, artry, aack | exp br, exp ts, exp amon, exp ready}
    // expected values are the active-high outputs seen in the cycle the inputs are applied
    localparam logic [7:0] VEC [24] = '{
        8'b1000_0001, // v0  idle, push one
        8'b0100_1001, // v1  R2 request visible; grant sampled
        8'b0000_0111, // v2  R3 R4 R5 start while grant gone, br drops
        8'b0100_0011, // v3  R7 grant during tenure, nothing waiting
        8'b0001_0011, // v4  acknowledge
        8'b1000_0001, // v5  R6 monitor released; push
        8'b1000_1001, // v6  push second
        8'b1000_1000, // v7  R10 full, push dropped
        8'b0100_1000, // v8  grant -> launch
        8'b0100_1110, // v9  R5 br stays (second waiting)
        8'b0100_1010, // v10 R7 grant held, no second start
        8'b0111_1010, // v11 R8 retry with ack: retry wins
        8'b0100_1000, // v12 R8 requeued, relaunch
        8'b0001_1110, // v13 R6 ack in start cycle
        8'b0000_1001, // v14 monitor off next cycle
        8'b0110_1001, // v15 R9 retry blocks grant
        8'b0100_1001, // v16 launch last
        8'b0000_0111, // v17 R10 dropped push not present: br off
        8'b0010_0011, // v18 R8 retry in wait
        8'b0000_1001, // v19 br back, monitor off
        8'b0100_1001, // v20 relaunch
        8'b0000_0111, // v21 start
        8'b0001_0011, // v22 ack
        8'b0000_0001  // v23 idle
    };

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_outs(input string note, input logic e_br, input logic e_ts,
                              input logic e_am, input logic e_rdy);
        check({note, " R2/R5 br"}, ~br_n, e_br);
        check({note, " R3 ts"}, ~ts_n, e_ts);
        check({note, " R6 amon"}, ~amon_n, e_am);
        check({note, " R10 ready"}, req_ready, e_rdy);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state, with grant asserted during reset
        bg = 1'b1;
        repeat (3) @(negedge clk);
        check_outs("R1 in reset", 1'b0, 1'b0, 1'b0, 1'b1);
        bg = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check_outs("R1 after reset", 1'b0, 1'b0, 1'b0, 1'b1);

        for (int i = 0; i < 24; i++) begin
            check_outs($sformatf("v%0d", i), VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
            {req_valid, bg, artry, aack} = VEC[i][7:4];
            @(negedge clk);
        end

        // R1 reset empties the queue: fill, reset, then offer a grant
        {req_valid, bg, artry, aack} = 4'b1000;
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
        check_outs("R1 filled", 1'b1, 1'b0, 1'b0, 1'b0);
        rst = 1'b1;
        bg  = 1'b1;
        @(negedge clk);
        check_outs("R1 reset with work", 1'b0, 1'b0, 1'b0, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_outs("R1 queue cleared", 1'b0, 1'b0, 1'b0, 1'b1);

        // R4 grant negated: request waits, no start
        bg = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        check_outs("R4 no grant", 1'b1, 1'b0, 1'b0, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule